// File: doc/BRIEF.md
# Program/Erase Suspend Arbiter

This block sits between a flash command decoder and the internal program/erase sequencer. It runs at most one long operation at a time: a whole-block erase or a single-word program. Each operation can be suspended and later resumed, and the resumed operation continues from the point where it was parked. While an operation is parked, the arbiter decides which new read and program requests may go ahead, based on the kind of operation that is parked and the block it targets.

The suspend rules are nested and asymmetric. A parked erase lets reads and programs proceed in any other block. A parked program lets only reads proceed, again only outside its own block. A program started during an erase suspend can itself be suspended, so two blocks can be parked at once. Reads are then allowed only outside both blocks. The erase can be resumed only after that inner program has been resumed and has finished. A suspend takes effect a fixed, parameterised number of cycles after it is accepted. All outputs are registered. A command presented before a clock edge produces its grant, error or state change in the cycle after that edge.

Top module: `pe_suspend_arbiter`

## Requirements
- R1: After a synchronous active-high reset, the state is idle (code 0), ready is 1, every grant, the error flag and the suspend acknowledge are 0, and the parked block index is 0.
- R2: An erase start in idle pulses the erase grant and moves the state to erasing (code 1) with ready 0. An erase start in any other state is refused: no grant, and the state is unchanged.
- R3: A program start in idle pulses the program grant and moves the state to programming (code 2) with ready 0.
- R4: The sequencer-done flag ends the running operation. Erasing and programming go back to idle. A program running inside an erase suspend (code 5) returns to erase-suspended (code 3).
- R5: A suspend accepted while erasing, programming or running a nested program moves the state, exactly SUS_LAT cycles later, to erase-suspended (3), program-suspended (4) or nested-program-suspended (6). The transition pulses the suspend acknowledge. Ready stays 0 until then.
- R6: While an erase is suspended, a read to any other block is granted. A program start to any other block is granted and moves the state to nested program (5).
- R7: While a program is suspended (code 4 or 6), program starts are never granted. Reads to blocks that are not parked are granted.
- R8: In a suspended state, a read or program start whose block equals a parked block gets no grant. It pulses the error flag and leaves the state unchanged.
- R9: Resume moves 3 to 1, 4 to 2 and 6 to 5. Resume is ignored in idle and while an operation is running.
- R10: Suspend is ignored in idle and in every suspended state.
- R11: A done flag that arrives while a suspend is pending completes the operation. The suspend is dropped, and no acknowledge is produced.
- R12: The parked block output shows the program's block in states 4 and 6, and the erase's block in states 3 and 5. It is 0 otherwise.
- R13: While an operation is running, reads and program starts get neither a grant nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_erase | input | 1 | Request a block erase of cmd_blk |
| start_prog | input | 1 | Request a word program in cmd_blk |
| suspend | input | 1 | Request suspension of the running operation |
| resume | input | 1 | Request continuation of the innermost parked operation |
| rd_req | input | 1 | Read request to cmd_blk |
| cmd_blk | input | BLK_W | Block index carried by the current command |
| seq_done | input | 1 | Sequencer reports that the running operation finished |
| state_o | output | 3 | Current state code (0 idle, 1 erasing, 2 programming, 3 erase suspended, 4 program suspended, 5 nested program, 6 nested program suspended) |
| sus_blk | output | BLK_W | Block index of the innermost parked operation |
| er_gnt | output | 1 | Erase start granted (pulse) |
| pg_gnt | output | 1 | Program start granted (pulse) |
| rd_gnt | output | 1 | Read granted (pulse) |
| blk_err | output | 1 | Request refused because it targets a parked block (pulse) |
| sus_ack | output | 1 | Suspension has taken effect (pulse) |
| ready | output | 1 | High when no operation is running |

## Verification
The bench builds the arbiter with SUS_LAT = 3 and BLK_W = 4. The three-cycle pending window lets a done flag, a repeated suspend or a stray command land between acceptance and acknowledge, which exercises the race in R11. Random block indices are drawn from only four values, so requests collide with one or both parked blocks often. This covers the nested erase/program suspension with two parked blocks.

// File: rtl/psa_pkg.sv
`timescale 1ns/1ps
package psa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ERASE = 3'd1,
    ST_PROG  = 3'd2,
    ST_ESUS  = 3'd3,
    ST_PSUS  = 3'd4,
    ST_NPROG = 3'd5,
    ST_NSUS  = 3'd6
  } op_state_e;

  function automatic logic is_running(op_state_e s);
    return (s == ST_ERASE) || (s == ST_PROG) || (s == ST_NPROG);
  endfunction

  // parked state reached when a running state is suspended
  function automatic op_state_e park_of(op_state_e s);
    case (s)
      ST_ERASE: return ST_ESUS;
      ST_PROG:  return ST_PSUS;
      ST_NPROG: return ST_NSUS;
      default:  return s;
    endcase
  endfunction

  // running state restored by a resume
  function automatic op_state_e wake_of(op_state_e s);
    case (s)
      ST_ESUS: return ST_ERASE;
      ST_PSUS: return ST_PROG;
      ST_NSUS: return ST_NPROG;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/psa_sus_timer.sv
`timescale 1ns/1ps
module psa_sus_timer #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic cancel,
  output logic pend,
  output logic fire
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      cnt  <= '0;
    end else if (cancel) begin
      pend <= 1'b0;
    end else if (arm) begin
      pend <= 1'b1;
      cnt  <= LOAD;
    end else if (pend) begin
      if (cnt == '0) pend <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign fire = pend && (cnt == '0);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    pend |-> (cnt <= LOAD)) else $error("count out of range"); // R5
  AST_FIRE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (fire && !arm) |=> !pend) else $error("pending stuck after fire"); // R5
endmodule

// File: rtl/psa_blk_guard.sv
`timescale 1ns/1ps
module psa_blk_guard
  import psa_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  op_state_e         st,
  input  logic [BLK_W-1:0]  ers_blk,
  input  logic [BLK_W-1:0]  prg_blk,
  input  logic [BLK_W-1:0]  req_blk,
  output logic              hit
);
  localparam int SLOTS = 2;

  logic [SLOTS-1:0][BLK_W-1:0] slot_blk;
  logic [SLOTS-1:0]            slot_en;
  logic [SLOTS-1:0]            slot_hit;

  // slot 0: parked erase, slot 1: parked program
  assign slot_blk[0] = ers_blk;
  assign slot_blk[1] = prg_blk;
  assign slot_en[0]  = (st == ST_ESUS) || (st == ST_NSUS);
  assign slot_en[1]  = (st == ST_PSUS) || (st == ST_NSUS);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_hit[g] = slot_en[g] && (slot_blk[g] == req_blk);
  end

  assign hit = |slot_hit;
endmodule

// File: rtl/pe_suspend_arbiter.sv
`timescale 1ns/1ps
module pe_suspend_arbiter
  import psa_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int SUS_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_erase,
  input  logic             start_prog,
  input  logic             suspend,
  input  logic             resume,
  input  logic             rd_req,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             seq_done,
  output logic [2:0]       state_o,
  output logic [BLK_W-1:0] sus_blk,
  output logic             er_gnt,
  output logic             pg_gnt,
  output logic             rd_gnt,
  output logic             blk_err,
  output logic             sus_ack,
  output logic             ready
);
  op_state_e        st, st_n;
  logic [BLK_W-1:0] ers_blk, prg_blk, e_n, p_n, sb_n;
  logic             eg_n, pg_n, rg_n, err_n, ack_n, rdy_n;
  logic             running, hit, pend, fire, arm, cancel;

  assign running = is_running(st);
  assign arm     = running && suspend && !seq_done && !pend;
  assign cancel  = running && seq_done;

  psa_sus_timer #(.LAT(SUS_LAT)) u_timer (
    .clk(clk), .rst(rst), .arm(arm), .cancel(cancel), .pend(pend), .fire(fire)
  );

  psa_blk_guard #(.BLK_W(BLK_W)) u_guard (
    .st(st), .ers_blk(ers_blk), .prg_blk(prg_blk), .req_blk(cmd_blk), .hit(hit)
  );

  // one command strobe per cycle is expected; priority otherwise is
  // resume, erase, program, read
  always_comb begin
    st_n  = st;
    e_n   = ers_blk;
    p_n   = prg_blk;
    eg_n  = 1'b0;
    pg_n  = 1'b0;
    rg_n  = 1'b0;
    err_n = 1'b0;
    ack_n = 1'b0;
    if (running) begin
      if (seq_done) begin
        st_n = (st == ST_NPROG) ? ST_ESUS : ST_IDLE;
      end else if (fire) begin
        st_n  = park_of(st);
        ack_n = 1'b1;
      end
    end else if (resume && (st != ST_IDLE)) begin
      st_n = wake_of(st);
    end else if (start_erase) begin
      if (st == ST_IDLE) begin
        eg_n = 1'b1;
        st_n = ST_ERASE;
        e_n  = cmd_blk;
      end
    end else if (start_prog) begin
      if (hit) begin
        err_n = 1'b1;
      end else if (st == ST_IDLE || st == ST_ESUS) begin
        pg_n = 1'b1;
        p_n  = cmd_blk;
        st_n = (st == ST_IDLE) ? ST_PROG : ST_NPROG;
      end
    end else if (rd_req) begin
      if (hit) err_n = 1'b1;
      else     rg_n  = 1'b1;
    end
  end

  always_comb begin
    case (st_n)
      ST_PSUS, ST_NSUS:  sb_n = p_n;
      ST_ESUS, ST_NPROG: sb_n = e_n;
      default:           sb_n = '0;
    endcase
    rdy_n = !is_running(st_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ers_blk <= '0;
      prg_blk <= '0;
      sus_blk <= '0;
      er_gnt  <= 1'b0;
      pg_gnt  <= 1'b0;
      rd_gnt  <= 1'b0;
      blk_err <= 1'b0;
      sus_ack <= 1'b0;
      ready   <= 1'b1;
    end else begin
      st      <= st_n;
      ers_blk <= e_n;
      prg_blk <= p_n;
      sus_blk <= sb_n;
      er_gnt  <= eg_n;
      pg_gnt  <= pg_n;
      rd_gnt  <= rg_n;
      blk_err <= err_n;
      sus_ack <= ack_n;
      ready   <= rdy_n;
    end
  end

  assign state_o = st;

  AST_ERASE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    er_gnt |-> ($past(st) == ST_IDLE)) else $error("erase granted outside idle"); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    is_running(st) |-> !ready) else $error("ready while running"); // R5
  AST_ACK_PARKED: assert property (@(posedge clk) disable iff (rst)
    sus_ack |-> (st == ST_ESUS || st == ST_PSUS || st == ST_NSUS)) else $error("ack without park"); // R5
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({er_gnt, pg_gnt, rd_gnt, blk_err})) else $error("several results"); // R8
  AST_ERR_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    blk_err |-> (st == $past(st))) else $error("error changed state"); // R8
  AST_NO_PROG_IN_PSUS: assert property (@(posedge clk) disable iff (rst)
    pg_gnt |-> !($past(st) == ST_PSUS || $past(st) == ST_NSUS)) else $error("program during program suspend"); // R7
  AST_NEST_OTHER_BLK: assert property (@(posedge clk) disable iff (rst)
    (pg_gnt && $past(st) == ST_ESUS) |-> ($past(cmd_blk) != ers_blk)) else $error("program into erased block"); // R6
  AST_RESUME_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && resume && !start_erase && !start_prog && !rd_req) |=> (st == ST_IDLE))
    else $error("resume left idle"); // R9
endmodule

// File: tb/pe_suspend_arbiter_tb.sv
`timescale 1ns/1ps
module pe_suspend_arbiter_tb;
  localparam int BW  = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst;
  logic start_erase, start_prog, suspend, resume, rd_req, seq_done;
  logic [BW-1:0] cmd_blk;
  logic [2:0]    state_o;
  logic [BW-1:0] sus_blk;
  logic er_gnt, pg_gnt, rd_gnt, blk_err, sus_ack, ready;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  int m_st, m_e, m_p, m_cnt;
  bit m_pend;
  logic [BW+8:0] exp_v;

  always #2.5 clk = ~clk;

  pe_suspend_arbiter #(.BLK_W(BW), .SUS_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .start_erase(start_erase), .start_prog(start_prog),
    .suspend(suspend), .resume(resume), .rd_req(rd_req), .cmd_blk(cmd_blk),
    .seq_done(seq_done), .state_o(state_o), .sus_blk(sus_blk), .er_gnt(er_gnt),
    .pg_gnt(pg_gnt), .rd_gnt(rd_gnt), .blk_err(blk_err), .sus_ack(sus_ack), .ready(ready)
  );

  function automatic bit parked_hit(int st, int e, int p, int b);
    return ((st == 3 || st == 6) && b == e) || ((st == 4 || st == 6) && b == p);
  endfunction

  function automatic bit runs(int st);
    return st == 1 || st == 2 || st == 5;
  endfunction

  // commands: 0 none, 1 erase, 2 program, 3 suspend, 4 resume, 5 read
  task automatic model(input int c, input int b, input bit d);
    bit eg = 0, pg = 0, rg = 0, er = 0, ak = 0;
    int sb;
    if (runs(m_st)) begin
      if (d) begin
        m_st = (m_st == 5) ? 3 : 0; m_pend = 0;
      end else if (m_pend) begin
        if (m_cnt == 0) begin
          m_st = (m_st == 1) ? 3 : (m_st == 2) ? 4 : 6; m_pend = 0; ak = 1;
        end else m_cnt--;
      end else if (c == 3) begin
        m_pend = 1; m_cnt = LAT - 1;
      end
    end else if (c == 4 && m_st != 0) begin
      m_st = (m_st == 3) ? 1 : (m_st == 4) ? 2 : 5;
    end else if (c == 1) begin
      if (m_st == 0) begin eg = 1; m_st = 1; m_e = b; end
    end else if (c == 2) begin
      if (parked_hit(m_st, m_e, m_p, b)) er = 1;
      else if (m_st == 0 || m_st == 3) begin
        pg = 1; m_p = b; m_st = (m_st == 0) ? 2 : 5;
      end
    end else if (c == 5) begin
      if (parked_hit(m_st, m_e, m_p, b)) er = 1; else rg = 1;
    end
    sb = (m_st == 4 || m_st == 6) ? m_p : (m_st == 3 || m_st == 5) ? m_e : 0;
    exp_v = {3'(m_st), BW'(sb), eg, pg, rg, er, ak, !runs(m_st)};
  endtask

  task automatic check(input string tag, input logic [BW+8:0] act, input logic [BW+8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int c, input int b, input bit d, input string tag);
    @(negedge clk);
    start_erase = (c == 1); start_prog = (c == 2); suspend = (c == 3);
    resume = (c == 4); rd_req = (c == 5); cmd_blk = BW'(b); seq_done = d;
    model(c, b, d);
    @(posedge clk); #1;
    check(tag, {state_o, sus_blk, er_gnt, pg_gnt, rd_gnt, blk_err, sus_ack, ready}, exp_v);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; start_erase = 0; start_prog = 0; suspend = 0; resume = 0;
    rd_req = 0; seq_done = 0; cmd_blk = '0;
    m_st = 0; m_e = 0; m_p = 0; m_cnt = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 reset", {state_o, sus_blk, er_gnt, pg_gnt, rd_gnt, blk_err, sus_ack, ready},
          {3'd0, BW'(0), 6'b000001});

    // nested erase / program suspension
    cyc(5, 2, 0, "R1 read in idle");
    cyc(1, 2, 0, "R2 erase start");
    cyc(1, 3, 0, "R2 erase refused while busy");
    cyc(5, 1, 0, "R13 read while running");
    cyc(2, 1, 0, "R13 program while running");
    cyc(4, 0, 0, "R9 resume while running ignored");
    cyc(3, 0, 0, "R5 suspend erase");
    cyc(0, 0, 0, "R5 pending 1");
    cyc(0, 0, 0, "R5 pending 2");
    cyc(0, 0, 0, "R5 erase parked");
    cyc(0, 0, 0, "R12 erase block shown");
    cyc(3, 0, 0, "R10 suspend while parked ignored");
    cyc(1, 7, 0, "R2 erase refused while parked");
    cyc(5, 2, 0, "R8 read to erased block");
    cyc(5, 1, 0, "R6 read other block");
    cyc(2, 2, 0, "R8 program to erased block");
    cyc(2, 3, 0, "R6 nested program");
    cyc(3, 0, 0, "R5 suspend nested program");
    repeat (LAT) cyc(0, 0, 0, "R5 nested park");
    cyc(2, 0, 0, "R7 program refused");
    cyc(5, 3, 0, "R8 read to program block");
    cyc(5, 2, 0, "R8 read to erase block");
    cyc(5, 1, 0, "R7 read other block");
    cyc(4, 0, 0, "R9 resume nested program");
    cyc(0, 0, 1, "R4 nested done");
    cyc(4, 0, 0, "R9 resume erase");
    cyc(0, 0, 1, "R4 erase done");
    cyc(4, 0, 0, "R9 resume in idle ignored");
    cyc(3, 0, 0, "R10 suspend in idle ignored");
    // done racing a pending suspend
    cyc(2, 5, 0, "R3 program start");
    cyc(3, 0, 0, "R11 suspend program");
    cyc(0, 0, 0, "R11 pending");
    cyc(0, 0, 1, "R11 done cancels suspend");
    cyc(0, 0, 0, "R11 no late ack");
    cyc(0, 0, 0, "R11 still idle");
    // plain program suspension
    cyc(2, 6, 0, "R3 program start");
    cyc(3, 0, 0, "R5 suspend program");
    repeat (LAT) cyc(0, 0, 0, "R5 program park");
    cyc(2, 1, 0, "R7 program refused in program suspend");
    cyc(5, 6, 0, "R8 read to programmed block");
    cyc(5, 4, 0, "R12 read other block");
    cyc(4, 0, 0, "R9 resume program");
    cyc(0, 0, 1, "R4 program done");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r, c;
      string tg;
      r = int'($urandom % 8);
      c = (r == 6) ? 5 : (r == 7) ? 0 : r;
      case (c)
        1: tg = "R2 random"; 2: tg = "R6 random"; 3: tg = "R5 random";
        4: tg = "R9 random"; 5: tg = "R7 random"; default: tg = "R4 random";
      endcase
      cyc(c, int'($urandom % 4), ($urandom % 6) == 0, tg);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule